// File: doc/BRIEF.md
# Sixteen-bit flag-generating ALU

A purely combinational 16-bit arithmetic-logic unit for the execute stage of a small processor with separate code and data memories. Each cycle it takes two operands, an incoming carry and a 4-bit operation code. It returns a 16-bit result and the next values of five condition flags: zero, carry, negative, overflow and parity. It also returns two write enables, one for the flags and one for the destination register.

The adder family covers plain add and subtract, their carry-chaining variants, negate, compare, and add or compare with a 4-bit signed immediate. The logic family covers AND, OR, XOR and NOT. A third group of data-movement operations produces register values without touching the flags. This group covers sign-extension of the low byte, loading a signed 8-bit constant, and two byte-merge loads that replace one half of the destination and keep the other half. For every operation, `a_i` carries the first source or the old destination value. `b_i` carries the second source or the constant.

Top module: `alu16_core`

## Requirements
- R1: Add (op 0) gives a_i + b_i and add-with-carry (op 2) gives a_i + b_i + c_i, both modulo 2^16. c_o is bit 16 of the unrounded sum.
- R2: Subtract (op 1), subtract-with-borrow (op 3, a_i - b_i - c_i), compare (op 9) and negate (op 8, 0 - a_i) give the modulo-2^16 difference. c_o is 1 exactly when the unsigned minuend is less than the subtrahend plus the incoming borrow.
- R3: For ops 0, 1, 2, 3, 8, 9, 10 and 11, v_o is 1 exactly when the true signed result lies outside -32768..32767.
- R4: Whenever flag_we_o is 1, z_o = 1 iff res_o is zero and n_o = res_o[15]. p_o = 1 iff res_o holds an even number of one bits.
- R5: AND (op 4), OR (op 5), XOR (op 6) and NOT (op 7, ~a_i) give the bitwise result with c_o = 0 and v_o = 0.
- R6: Compare (op 9) and compare-immediate (op 11) assert flag_we_o and deassert res_we_o. Every other op asserts res_we_o.
- R7: Add-immediate (op 10) and compare-immediate (op 11) use b_i[3:0] as a signed value in -8..7 in place of b_i and ignore b_i[15:4].
- R8: Load-low (op 13) gives {a_i[15:8], b_i[7:0]} and load-high (op 14) gives {b_i[7:0], a_i[7:0]}. Both have flag_we_o = 0.
- R9: Sign-extend (op 12) copies a_i[7] into bits 15:8 above a_i[7:0]. Load-byte (op 15) sign-extends b_i[7:0]. Both have flag_we_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand / old destination value |
| b_i | input | 16 | Second operand / constant |
| c_i | input | 1 | Current carry flag |
| res_o | output | 16 | Result |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry/borrow flag |
| n_o | output | 1 | Next negative flag |
| v_o | output | 1 | Next overflow flag |
| p_o | output | 1 | Next even-parity flag |
| flag_we_o | output | 1 | Flags are to be written |
| res_we_o | output | 1 | Result is to be written |

## Verification
The bench sweeps every op code against a grid of boundary operands: 0, 1, the signed extremes, 0x00FF/0x0080 and all-ones, with both carry values. It then adds a long pseudo-random run.

The sweep targets several specific errors:
- A carry taken as a non-inverted adder carry-out on subtract shows up as a wrong borrow at a_i == b_i and at a_i == b_i + 1 with borrow in.
- An overflow test that uses the raw b operand on subtract misflags 0x8000 - 1.
- An immediate that is zero-extended turns an add of -1 into an add of 15.
- A byte-merge that clears the kept half, or a parity of odd sense, fails at the first nonzero vector.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDC = 4'd2,  OP_SUBB = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_NOT  = 4'd7,
    OP_NEG  = 4'd8,  OP_CMP  = 4'd9,  OP_ADDI = 4'd10, OP_CMPI = 4'd11,
    OP_SEXT = 4'd12, OP_LDLO = 4'd13, OP_LDHI = 4'd14, OP_LDB  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_MOVE  = 2'd2
  } alu_grp_e;

  typedef struct packed {
    alu_grp_e grp;
    logic     sub;      // adder subtracts
    logic     use_cin;  // incoming carry/borrow participates
    logic     use_imm;  // short signed immediate replaces b
    logic     negate;   // zero minus a
    logic     res_we;
    logic     flag_we;
  } alu_ctl_t;
endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '{grp: GRP_ARITH, sub: 1'b0, use_cin: 1'b0, use_imm: 1'b0,
              negate: 1'b0, res_we: 1'b1, flag_we: 1'b1};
    unique case (alu_op_e'(op_i))
      OP_ADD:  ;
      OP_SUB:  ctl_o.sub = 1'b1;
      OP_ADDC: ctl_o.use_cin = 1'b1;
      OP_SUBB: begin ctl_o.sub = 1'b1; ctl_o.use_cin = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: ctl_o.grp = GRP_LOGIC;
      OP_NEG:  begin ctl_o.sub = 1'b1; ctl_o.negate = 1'b1; end
      OP_CMP:  begin ctl_o.sub = 1'b1; ctl_o.res_we = 1'b0; end
      OP_ADDI: ctl_o.use_imm = 1'b1;
      OP_CMPI: begin ctl_o.sub = 1'b1; ctl_o.use_imm = 1'b1; ctl_o.res_we = 1'b0; end
      OP_SEXT, OP_LDLO, OP_LDHI, OP_LDB: begin
        ctl_o.grp     = GRP_MOVE;
        ctl_o.flag_we = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             sub_i,
  input  logic             cin_i,   // carry for add, borrow for subtract
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] y_eff;
  logic             ci_eff;
  logic [EXT_W-1:0] ext;

  always_comb begin
    y_eff  = sub_i ? ~y_i : y_i;
    ci_eff = sub_i ? ~cin_i : cin_i;
    ext    = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, ci_eff};
    sum_o  = ext[WIDTH-1:0];
    c_o    = sub_i ? ~ext[WIDTH] : ext[WIDTH];
    v_o    = (x_i[WIDTH-1] == y_eff[WIDTH-1]) && (ext[WIDTH-1] != x_i[WIDTH-1]);
  end

  always_comb begin
    if (sub_i && !cin_i) begin
      // R2
      sub_borrow_chk: assert (c_o == (x_i < y_i))
        else $error("borrow does not match unsigned compare");
    end
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SEXT: res_o = {{(WIDTH-HALF){a_i[HALF-1]}}, a_i[HALF-1:0]};
      OP_LDLO: res_o = {a_i[WIDTH-1:HALF], b_i[HALF-1:0]};
      OP_LDHI: res_o = {b_i[HALF-1:0], a_i[HALF-1:0]};
      OP_LDB:  res_o = {{(WIDTH-HALF){b_i[HALF-1]}}, b_i[HALF-1:0]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             z_o,
  output logic             n_o,
  output logic             p_o
);
  always_comb begin
    z_o = ~|res_i;
    n_o = res_i[WIDTH-1];
    p_o = ~^res_i;   // even parity
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 4
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             z_o,
  output logic             c_o,
  output logic             n_o,
  output logic             v_o,
  output logic             p_o,
  output logic             flag_we_o,
  output logic             res_we_o
);
  localparam int HALF = WIDTH / 2;

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] x_op, y_op, imm_ext;
  logic [WIDTH-1:0] sum, lres;
  logic             add_c, add_v, cin_eff;

  alu16_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  always_comb begin
    imm_ext = {{(WIDTH-IMM_W){b_i[IMM_W-1]}}, b_i[IMM_W-1:0]};
    x_op    = ctl.negate ? '0 : a_i;
    y_op    = ctl.negate ? a_i : (ctl.use_imm ? imm_ext : b_i);
    cin_eff = ctl.use_cin & c_i;
  end

  alu16_addsub #(.WIDTH(WIDTH)) u_add (
    .x_i(x_op), .y_i(y_op), .sub_i(ctl.sub), .cin_i(cin_eff),
    .sum_o(sum), .c_o(add_c), .v_o(add_v)
  );

  alu16_logic #(.WIDTH(WIDTH)) u_log (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  always_comb begin
    if (ctl.grp == GRP_ARITH) begin
      res_o = sum;
      c_o   = add_c;
      v_o   = add_v;
    end else begin
      res_o = lres;
      c_o   = 1'b0;
      v_o   = 1'b0;
    end
    flag_we_o = ctl.flag_we;
    res_we_o  = ctl.res_we;
  end

  alu16_flags #(.WIDTH(WIDTH)) u_flg (
    .res_i(res_o), .z_o(z_o), .n_o(n_o), .p_o(p_o)
  );

  always_comb begin
    // R4
    zero_parity_chk: assert (!z_o || (!n_o && p_o))
      else $error("zero result with sign or odd parity");
    if (ctl.grp == GRP_LOGIC) begin
      // R5
      logic_flags_chk: assert (!c_o && !v_o)
        else $error("logic op left carry or overflow set");
    end
    if (op_i == OP_CMP || op_i == OP_CMPI) begin
      // R6
      cmp_nowrite_chk: assert (!res_we_o && flag_we_o)
        else $error("compare writes a register or skips flags");
    end
    if (op_i == OP_LDLO) begin
      // R8
      ldlo_keep_chk: assert (res_o[WIDTH-1:HALF] == a_i[WIDTH-1:HALF] && !flag_we_o)
        else $error("load-low disturbed the upper byte");
    end
    if (op_i == OP_SEXT) begin
      // R9
      sext_fill_chk: assert (res_o[WIDTH-1:HALF] == {HALF{a_i[HALF-1]}})
        else $error("sign-extend fill wrong");
    end
  end
endmodule

// File: tb/alu16_core_bench.sv
module alu16_core_bench;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [15:0] a, b, res;
  logic        cin, z, c, n, v, p, fwe, rwe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu16_core u_alu16_core (
    .op_i(op), .a_i(a), .b_i(b), .c_i(cin), .res_o(res),
    .z_o(z), .c_o(c), .n_o(n), .v_o(v), .p_o(p),
    .flag_we_o(fwe), .res_we_o(rwe)
  );

  function automatic int sx(input int val, input int bits);
    int m = 1 << bits;
    val = val % m;
    return (val >= m / 2) ? val - m : val;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d act=%h exp=%h", tag, op, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input int o, input int av, input int bv, input int cv);
    int r, ec, ev, efwe, erwe, ones, sa, sb, sr, bb;
    string ctag;
    @(negedge clk);
    op = 4'(o); a = 16'(av); b = 16'(bv); cin = cv[0];
    @(posedge clk); #1;
    ec = 0; ev = 0; efwe = 1; erwe = 1; sr = 0; ctag = "R1_c";
    sa = sx(av, 16); sb = sx(bv, 16);
    bb = (o == 10 || o == 11) ? (sx(bv & 15, 4) & 16'hFFFF) : bv;
    if (o == 10 || o == 11) sb = sx(bv & 15, 4);
    case (o)
      0, 2, 10: begin
        r  = av + bb + ((o == 2) ? cv : 0);
        ec = (r >> 16) & 1;
        sr = sa + sb + ((o == 2) ? cv : 0);
        r  = r & 16'hFFFF;
      end
      1, 3, 9, 11: begin
        int bin = (o == 3) ? cv : 0;
        r  = (av - bb - bin) & 16'hFFFF;
        ec = (av < bb + bin) ? 1 : 0;
        sr = sa - sb - bin;
        ctag = "R2_c";
        if (o == 9 || o == 11) erwe = 0;
      end
      8: begin
        r = (0 - av) & 16'hFFFF; ec = (av != 0) ? 1 : 0; sr = -sa; ctag = "R2_c";
      end
      4: begin r = av & bv; ctag = "R5_c"; end
      5: begin r = av | bv; ctag = "R5_c"; end
      6: begin r = av ^ bv; ctag = "R5_c"; end
      7: begin r = (~av) & 16'hFFFF; ctag = "R5_c"; end
      12: begin r = sx(av & 255, 8) & 16'hFFFF; efwe = 0; end
      13: begin r = (av & 16'hFF00) | (bv & 255); efwe = 0; end
      14: begin r = (av & 255) | ((bv & 255) << 8); efwe = 0; end
      default: begin r = sx(bv & 255, 8) & 16'hFFFF; efwe = 0; end
    endcase
    if (o <= 3 || (o >= 8 && o <= 11)) ev = (sr > 32767 || sr < -32768) ? 1 : 0;
    ones = 0;
    for (int i = 0; i < 16; i++) ones += (r >> i) & 1;
    if (o == 13 || o == 14) chk("R8_res", res, r);
    else if (o == 12 || o == 15) chk("R9_res", res, r);
    else if (o >= 4 && o <= 7) chk("R5_res", res, r);
    else if (o == 10 || o == 11) chk("R7_res", res, r);
    else if (o == 0 || o == 2) chk("R1_res", res, r);
    else chk("R2_res", res, r);
    chk("R6_rwe", rwe, erwe);
    chk((efwe == 0) ? "R8_R9_fwe" : "R6_fwe", fwe, efwe);
    if (efwe == 1) begin
      chk(ctag, c, ec);
      chk((o >= 4 && o <= 7) ? "R5_v" : "R3_v", v, ev);
      chk("R4_z", z, (r == 0) ? 1 : 0);
      chk("R4_n", n, (r >> 15) & 1);
      chk("R4_p", p, (ones % 2 == 0) ? 1 : 0);
    end
  endtask

  int grid [12] = '{16'h0000, 16'h0001, 16'h0007, 16'h0008, 16'h007F, 16'h0080,
                    16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hA5CF};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    op = 4'd0; a = '0; b = '0; cin = 1'b0;
    // idle vector: add of zeros (R1, R4)
    apply(0, 0, 0, 0);
    // R7: immediate -1 must subtract, upper b bits ignored
    apply(10, 16'h0005, 16'hFFFF, 0);
    apply(10, 16'h0005, 16'h000F, 0);
    apply(11, 16'h8000, 16'h0001, 1);
    // R2 borrow boundary with borrow in
    apply(3, 16'h0005, 16'h0004, 1);
    // R3: 0x8000 - 1 overflows
    apply(1, 16'h8000, 16'h0001, 0);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int k = 0; k < 2; k++)
            apply(o, grid[i], grid[j], k);
    lfsr = 32'hACE1_1234;
    for (int t = 0; t < 3000; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(int'(lfsr[3:0]), int'(lfsr[19:4]), int'({lfsr[15:0]} ^ 16'h5A3C), int'(lfsr[31]));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule